// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Sequencer

This block carries out entry into privileged mode when the core takes an exception. A request gives a cause code and, for trap calls into the privileged library, a function code. In the accepting cycle the block computes the handler address as a writable base register plus an offset chosen by the cause. It records the return address, with bit 0 set to show whether the trap came from privileged mode, and loads the new PC.

When the core enters privileged mode from normal mode, the block exchanges eight architectural integer registers with an internal shadow bank in a single exchange. A second exception taken while the core is already privileged leaves both banks as they are.

Instruction decode, choosing between simultaneous causes and the return path are outside this block. The return path reaches the mode flag through a plain write port.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause codes 0 to 9 (reset 0, machine check 1, interprocessor interrupt 2, clock interrupt 3, device interrupt 4, memory fault 5, unaligned 6, illegal opcode 7, arithmetic 8, floating point disabled 9) select offsets 0x0000, 0x0080, 0x0100, 0x0180, 0x0200, 0x0280, 0x0300, 0x0380, 0x0400 and 0x0480 in that order.
- R2: Cause 10 is a trap call. When bit 7 of the function code is set, the offset is 0x2000 + (code - 0x80) * 64.
- R3: For a trap call with function-code bit 7 clear, the offset is 0x1000 + code * 64.
- R4: On the clock edge that samples an accepted request, newPc becomes base + offset and pcLoad is high for the following cycle only.
- R5: On that same edge, excAddr captures curPc with bit 0 replaced by the mode flag held before the exception.
- R6: An accepted request from normal mode sets the mode flag. On the same edge archOut slot k takes shadow entry k, shadow entry k takes archIn slot k, and archWe pulses for one cycle. Slot k is register 8+k for k = 0 to 6 and register 25 for k = 7, with slot k at bits [k*64 +: 64].
- R7: An accepted request while already privileged performs no exchange: archWe stays low and the shadow contents are kept.
- R8: Cause codes 11 to 15 pulse excErr for one cycle. They leave newPc, pcLoad, excAddr, the mode flag and the shadow bank unchanged.
- R9: excDone pulses for exactly one cycle after each accepted request, which retires the pending request.
- R10: baseWrEn loads baseWrData into the base register. An exception accepted on the same edge uses the old base.
- R11: modeWrEn loads modeWrData into the mode flag. If an exception is accepted on the same edge, the exception's set wins.
- R12: After reset the mode flag, pcLoad, excDone, excErr and archWe are 0, and newPc, excAddr, the base and the shadow bank are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| excValid | input | 1 | exception request, one per cycle high |
| excCause | input | 4 | cause code |
| excFunc | input | 8 | trap-call function code |
| curPc | input | 64 | PC of the excepting instruction |
| baseWrEn | input | 1 | base register write strobe |
| baseWrData | input | 64 | base register write value |
| modeWrEn | input | 1 | mode flag write strobe |
| modeWrData | input | 1 | mode flag write value |
| archIn | input | 512 | current values of the eight swapped registers |
| privMode | output | 1 | privileged-mode flag |
| pcLoad | output | 1 | newPc valid pulse |
| newPc | output | 64 | handler address |
| excAddr | output | 64 | saved return address with mode bit |
| excDone | output | 1 | request accepted pulse |
| excErr | output | 1 | unknown cause pulse |
| archWe | output | 1 | register file write-back strobe for the exchange |
| archOut | output | 512 | values to write into the eight registers |

## Verification
The hardest case to reach from the ports is a second normal-to-privileged exchange. It shows that the shadow bank kept the values captured by the first exchange, including across nested exceptions that must not touch it. The stimulus enters privileged mode, takes several nested exceptions, clears the mode through the write port and then takes a fresh exception. The bench checks that archOut returns exactly the archIn values seen at the first entry. Same-edge collisions of an exception with a base write and with a mode write are driven on purpose to exercise R10 and R11.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_W    = 4;
  localparam int FUNC_W     = 8;
  localparam int OFF_W      = 14;
  localparam int VEC_SHIFT  = 7;   // 128-byte stride between fixed vectors
  localparam int SLOT_SHIFT = 6;   // 64-byte trap-call slots
  localparam int PRIV_BASE   = 'h1000;
  localparam int UNPRIV_BASE = 'h2000;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_RESET   = 4'd0,
    CAUSE_MCHECK  = 4'd1,
    CAUSE_IPI     = 4'd2,
    CAUSE_CLOCK   = 4'd3,
    CAUSE_DEVICE  = 4'd4,
    CAUSE_MMFAULT = 4'd5,
    CAUSE_ALIGN   = 4'd6,
    CAUSE_ILLOP   = 4'd7,
    CAUSE_ARITH   = 4'd8,
    CAUSE_FPOFF   = 4'd9,
    CAUSE_TRAP    = 4'd10
  } cause_e;

  typedef struct packed {
    logic             commit;
    logic             swap;
    logic             err;
    logic [OFF_W-1:0] offset;
  } ctrl_strobes_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                excValid,
  input  logic [CAUSE_W-1:0]  excCause,
  input  logic [FUNC_W-1:0]   excFunc,
  input  logic                privMode,
  output ctrl_strobes_t       strobes
);
  logic             knownCause;
  logic [OFF_W-1:0] trapOffset;
  logic [OFF_W-1:0] fixedOffset;

  assign knownCause  = (excCause <= CAUSE_TRAP);
  assign fixedOffset = OFF_W'({excCause, {VEC_SHIFT{1'b0}}});
  assign trapOffset  = (excFunc[FUNC_W-1] ? OFF_W'(UNPRIV_BASE) : OFF_W'(PRIV_BASE))
                     + OFF_W'({excFunc[FUNC_W-2:0], {SLOT_SHIFT{1'b0}}});

  always_comb begin
    strobes = '0;
    if (excValid) begin
      if (knownCause) begin
        strobes.commit = 1'b1;
        strobes.swap   = !privMode;
        strobes.offset = (excCause == CAUSE_TRAP) ? trapOffset : fixedOffset;
      end else begin
        strobes.err = 1'b1;
      end
    end
  end

  AST_COMMIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit && strobes.err)); // R8
  AST_NO_SWAP_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    privMode |-> !strobes.swap); // R7
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NSHADOW = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobes_t             strobes,
  input  logic [XLEN-1:0]           curPc,
  input  logic                      baseWrEn,
  input  logic [XLEN-1:0]           baseWrData,
  input  logic                      modeWrEn,
  input  logic                      modeWrData,
  input  logic [NSHADOW*XLEN-1:0]   archIn,
  output logic                      privMode,
  output logic                      pcLoad,
  output logic [XLEN-1:0]           newPc,
  output logic [XLEN-1:0]           excAddr,
  output logic                      excDone,
  output logic                      excErr,
  output logic                      archWe,
  output logic [NSHADOW*XLEN-1:0]   archOut
);
  logic [XLEN-1:0] baseQ;
  logic            modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      modeQ   <= 1'b0;
      newPc   <= '0;
      excAddr <= '0;
      pcLoad  <= 1'b0;
      excDone <= 1'b0;
      excErr  <= 1'b0;
      archWe  <= 1'b0;
    end else begin
      pcLoad  <= strobes.commit;
      excDone <= strobes.commit;
      excErr  <= strobes.err;
      archWe  <= strobes.swap;
      if (baseWrEn) baseQ <= baseWrData;
      if (strobes.commit) begin
        newPc   <= baseQ + XLEN'(strobes.offset);
        excAddr <= {curPc[XLEN-1:1], modeQ};
        modeQ   <= 1'b1;
      end else if (modeWrEn) begin
        modeQ <= modeWrData;
      end
    end
  end

  for (genvar k = 0; k < NSHADOW; k++) begin : g_bank
    logic [XLEN-1:0] shadowQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ                 <= '0;
        archOut[k*XLEN +: XLEN] <= '0;
      end else if (strobes.swap) begin
        shadowQ                 <= archIn[k*XLEN +: XLEN];
        archOut[k*XLEN +: XLEN] <= shadowQ;
      end
    end
  end

  assign privMode = modeQ;

  AST_DONE_SETS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    excDone |-> modeQ); // R6
  AST_SWAP_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    archWe |-> !$past(modeQ)); // R6
  AST_SAVED_MODE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    excDone |-> (excAddr[0] == $past(modeQ))); // R5
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(newPc)); // R8
  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    excErr |-> !pcLoad); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    excDone == pcLoad); // R9
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NSHADOW = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     excValid,
  input  logic [CAUSE_W-1:0]       excCause,
  input  logic [FUNC_W-1:0]        excFunc,
  input  logic [XLEN-1:0]          curPc,
  input  logic                     baseWrEn,
  input  logic [XLEN-1:0]          baseWrData,
  input  logic                     modeWrEn,
  input  logic                     modeWrData,
  input  logic [NSHADOW*XLEN-1:0]  archIn,
  output logic                     privMode,
  output logic                     pcLoad,
  output logic [XLEN-1:0]          newPc,
  output logic [XLEN-1:0]          excAddr,
  output logic                     excDone,
  output logic                     excErr,
  output logic                     archWe,
  output logic [NSHADOW*XLEN-1:0]  archOut
);
  ctrl_strobes_t strobes;

  exc_entry_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .excValid (excValid),
    .excCause (excCause),
    .excFunc  (excFunc),
    .privMode (privMode),
    .strobes  (strobes)
  );

  exc_entry_dp #(.XLEN(XLEN), .NSHADOW(NSHADOW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .curPc      (curPc),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .archIn     (archIn),
    .privMode   (privMode),
    .pcLoad     (pcLoad),
    .newPc      (newPc),
    .excAddr    (excAddr),
    .excDone    (excDone),
    .excErr     (excErr),
    .archWe     (archWe),
    .archOut    (archOut)
  );
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         excValid = 1'b0;
  logic [3:0]   excCause = '0;
  logic [7:0]   excFunc = '0;
  logic [63:0]  curPc = '0;
  logic         baseWrEn = 1'b0;
  logic [63:0]  baseWrData = '0;
  logic         modeWrEn = 1'b0;
  logic         modeWrData = 1'b0;
  logic [511:0] archIn = '0;
  logic         privMode, pcLoad, excDone, excErr, archWe;
  logic [63:0]  newPc, excAddr;
  logic [511:0] archOut;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCause(excCause),
    .excFunc(excFunc), .curPc(curPc), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .archIn(archIn), .privMode(privMode), .pcLoad(pcLoad), .newPc(newPc),
    .excAddr(excAddr), .excDone(excDone), .excErr(excErr), .archWe(archWe),
    .archOut(archOut)
  );

  always #5 clk = ~clk;

  integer checks = 0;
  integer fails = 0;
  integer cyc = 0;
  bit     finished = 1'b0;

  // behavioural reference
  logic        mMode, mPcLoad, mDone, mErr, mWe;
  logic [63:0] mBase, mPc, mExc;
  logic [63:0] mShadow [8];
  logic [63:0] mOut [8];

  function automatic integer refOffset(input integer cause, input integer fn);
    integer r;
    case (cause)
      0: r = 'h0000;  1: r = 'h0080;  2: r = 'h0100;  3: r = 'h0180;
      4: r = 'h0200;  5: r = 'h0280;  6: r = 'h0300;  7: r = 'h0380;
      8: r = 'h0400;  9: r = 'h0480;
      default: r = (fn >= 'h80) ? 'h2000 + (fn - 'h80) * 64 : 'h1000 + fn * 64;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode <= 0; mPcLoad <= 0; mDone <= 0; mErr <= 0; mWe <= 0;
      mBase <= 0; mPc <= 0; mExc <= 0;
      for (int k = 0; k < 8; k++) begin mShadow[k] <= 0; mOut[k] <= 0; end
    end else begin
      mPcLoad <= 0; mDone <= 0; mErr <= 0; mWe <= 0;
      if (baseWrEn) mBase <= baseWrData;
      if (excValid && excCause <= 10) begin
        mPc     <= mBase + 64'(refOffset(int'(excCause), int'(excFunc)));
        mExc    <= {curPc[63:1], mMode};
        mPcLoad <= 1; mDone <= 1; mMode <= 1;
        if (!mMode) begin
          mWe <= 1;
          for (int k = 0; k < 8; k++) begin
            mOut[k]    <= mShadow[k];
            mShadow[k] <= archIn[k*64 +: 64];
          end
        end
      end else begin
        if (excValid) mErr <= 1;
        if (modeWrEn) mMode <= modeWrData;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R6/R11 privMode", 64'(privMode), 64'(mMode));
    chk("R4 pcLoad", 64'(pcLoad), 64'(mPcLoad));
    chk("R1/R2/R3/R4/R10 newPc", newPc, mPc);
    chk("R5 excAddr", excAddr, mExc);
    chk("R9 excDone", 64'(excDone), 64'(mDone));
    chk("R8 excErr", 64'(excErr), 64'(mErr));
    chk("R6/R7 archWe", 64'(archWe), 64'(mWe));
    for (int k = 0; k < 8; k++) chk("R6/R7 archOut", archOut[k*64 +: 64], mOut[k]);
  endtask

  // one clock: edge, settle, compare, then clear pulses
  task automatic step();
    @(posedge clk); #1;
    cyc++;
    compareAll();
    excValid = 0; baseWrEn = 0; modeWrEn = 0;
    for (int k = 0; k < 8; k++) archIn[k*64 +: 64] = {32'hA500_0000 + 32'(cyc), 32'(k)};
  endtask

  task automatic raise(input int cause, input int fn, input logic [63:0] pc);
    excValid = 1; excCause = 4'(cause); excFunc = 8'(fn); curPc = pc;
    step();
  endtask

  task automatic setMode(input logic v);
    modeWrEn = 1; modeWrData = v;
    step();
  endtask

  initial begin
    rstN = 0;
    step(); step();
    rstN = 1;
    step();
    // R12: reset state explicit
    chk("R12 reset mode", 64'(privMode), 64'd0);
    chk("R12 reset newPc", newPc, 64'd0);
    chk("R12 reset archOut", archOut[63:0], 64'd0);
    baseWrEn = 1; baseWrData = 64'hFFFF_0000_0010_0000; step();       // R10
    // R1 fixed vectors, each from normal mode (R6 swap every time)
    for (int c = 0; c < 10; c++) begin
      raise(c, 0, 64'h1234_0000 + 64'(c * 4 + 1));
      chk("R1 offset", newPc - 64'hFFFF_0000_0010_0000, 64'(refOffset(c, 0)));
      setMode(0);
    end
    // R3 / R2 trap calls
    raise(10, 'h00, 64'h40); chk("R3 trap 0x00", newPc[15:0], 16'h1000); setMode(0);
    raise(10, 'h3F, 64'h44); chk("R3 trap 0x3F", newPc[15:0], 16'h1FC0); setMode(0);
    raise(10, 'h80, 64'h48); chk("R2 trap 0x80", newPc[15:0], 16'h2000);
    raise(10, 'hBF, 64'h4C); chk("R2 trap 0xBF", newPc[15:0], 16'h2FC0);
    raise(10, 'hFF, 64'h50);
    raise(10, 'h7F, 64'h55); chk("R5 priv bit", excAddr, 64'h55);
    // R7 nested exceptions while privileged, no swap
    raise(8, 0, 64'h100); chk("R7 no swap", 64'(archWe), 64'd0);
    // R8 unknown causes, in both modes
    raise(11, 0, 64'hDEAD); chk("R8 err", 64'(excErr), 64'd1);
    raise(15, 0, 64'hBEEF);
    setMode(0);
    raise(12, 0, 64'hCAFE); chk("R8 mode kept", 64'(privMode), 64'd0);
    step();
    // R10 base write same edge as exception: old base used
    baseWrEn = 1; baseWrData = 64'h0000_0000_8000_0000;
    raise(3, 0, 64'h2000);
    chk("R10 old base", newPc, 64'hFFFF_0000_0010_0180);
    setMode(0);
    raise(3, 0, 64'h2004);
    chk("R10 new base", newPc, 64'h0000_0000_8000_0180);
    // R11 mode clear same edge as exception: exception wins
    modeWrEn = 1; modeWrData = 0;
    raise(4, 0, 64'h3001);
    chk("R11 exc wins", 64'(privMode), 64'd1);
    // second normal entry returns earlier captured values
    setMode(0);
    raise(9, 0, 64'h3009);
    step(); step();
    // back-to-back requests
    setMode(0);
    raise(1, 0, 64'h10); raise(2, 0, 64'h20); raise(13, 0, 64'h30);
    step();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule